// File: doc/BRIEF.md
# Predicated Commit Gate with Status Flags

This block keeps the four-bit status word that a compare or subtract leaves behind, and decides for each issued result whether it may become architectural state. Every result arrives with a four-bit condition code, a valid strobe, an optional register-write request (destination and data) and an optional request to replace the status word with flags supplied by the arithmetic unit.

The condition is tested against the status word as it stood before the current result. A passing, valid result drives a single commit enable. That enable gates the register-file write port and the flag load. A result whose condition fails still takes its slot, but it writes no register and leaves the flags untouched.

"Above" and "below" tests treat the last comparison as unsigned, with a set carry meaning "below". "Greater" and "less" tests treat it as signed.

Top module: `pred_commit_unit`

## Requirements
- R1: After a synchronous active-high reset, `flags_q` is 4'b0000. `flags_q` and `alu_flags` share one layout: bit 3 sign (S), bit 2 carry (C), bit 1 overflow (V), bit 0 zero (Z).
- R2: Single-flag codes pass as follows: 4'b0000 when Z=0, 4'b0001 when Z=1, 4'b0010 when V=0, 4'b0011 when V=1, 4'b0100 when C=0, 4'b0101 when C=1, 4'b0110 when S=0, 4'b0111 when S=1.
- R3: Unsigned codes treat a set carry as "below". 4'b1000 (above) passes when C=0 and Z=0. 4'b1001 (below or same) passes when C=1 or Z=1.
- R4: Signed codes pass as follows: 4'b1010 (greater or equal) when S==V, 4'b1011 (less) when S!=V, 4'b1100 (greater) when Z=0 and S==V, 4'b1101 (less or equal) when Z=1 or S!=V.
- R5: Code 4'b1110 always passes and code 4'b1111 never passes, whatever the flags.
- R6: `commit_en` is low in any cycle where `res_valid` is low.
- R7: `rf_we` equals `commit_en & wr_req` in the same cycle. `rf_waddr` and `rf_wdata` carry `wr_dest` and `wr_data`.
- R8: When `commit_en` and `flag_upd` are both high at a rising edge, `flags_q` takes the value of `alu_flags` after that edge.
- R9: A result whose condition fails asserts neither `rf_we` nor a flag load. `flags_q` stays unchanged across that edge.
- R10: A result is judged on the flags stored before it. Flags it supplies itself affect only later results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | A result occupies this slot |
| cond_code | input | 4 | Predicate code for the result |
| wr_req | input | 1 | Result asks to write the register file |
| wr_dest | input | DEST_W | Destination register index |
| wr_data | input | DATA_W | Value to write |
| flag_upd | input | 1 | Result asks to replace the status word |
| alu_flags | input | 4 | New flags {S,C,V,Z} from the arithmetic unit |
| commit_en | output | 1 | Result may change architectural state |
| rf_we | output | 1 | Gated register-file write enable |
| rf_waddr | output | DEST_W | Register-file write index |
| rf_wdata | output | DATA_W | Register-file write data |
| flags_q | output | 4 | Stored status word {S,C,V,Z} |

## Verification
The hardest case to reach is a result that both reads and rewrites the flags. Its verdict must come from the old word, while the new word must appear only after the edge, and only if that verdict passed. The stimulus first plants a known status word with an always-passing flag update. It then issues results that carry their own flag updates, chosen so that judging on the new flags would flip the verdict. For each such result it observes `commit_en` before the edge and `flags_q` after it.

// File: rtl/pred_commit_unit.sv
module pred_commit_unit #(
  parameter int DEST_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [3:0]        cond_code,
  input  logic              wr_req,
  input  logic [DEST_W-1:0] wr_dest,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_upd,
  input  logic [3:0]        alu_flags,
  output logic              commit_en,
  output logic              rf_we,
  output logic [DEST_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [3:0]        flags_q
);

  localparam int BIT_Z = 0;
  localparam int BIT_V = 1;
  localparam int BIT_C = 2;
  localparam int BIT_S = 3;

  logic f_z, f_v, f_c, f_s;
  logic base_hit;
  logic cond_hit;

  assign f_z = flags_q[BIT_Z];
  assign f_v = flags_q[BIT_V];
  assign f_c = flags_q[BIT_C];
  assign f_s = flags_q[BIT_S];

  // Even codes test the predicate, odd codes its complement (pairs share cond_code[3:1]).
  always_comb begin
    unique case (cond_code[3:1])
      3'b000: base_hit = !f_z;
      3'b001: base_hit = !f_v;
      3'b010: base_hit = !f_c;
      3'b011: base_hit = !f_s;
      3'b100: base_hit = !f_c && !f_z;
      3'b101: base_hit = (f_s == f_v);
      3'b110: base_hit = !f_z && (f_s == f_v);
      default: base_hit = 1'b1;
    endcase
  end

  assign cond_hit  = base_hit ^ cond_code[0];
  assign commit_en = res_valid && cond_hit;

  assign rf_we    = commit_en && wr_req;
  assign rf_waddr = wr_dest;
  assign rf_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= 4'b0000;
    else if (commit_en && flag_upd)
      flags_q <= alu_flags;
  end

  AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !commit_en); // R6

  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'b1111) |-> !commit_en); // R5

  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (rst)
    (res_valid && cond_code == 4'b1110) |-> commit_en); // R5

  AST_WE_GATED: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (commit_en && wr_req)); // R7

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (commit_en && flag_upd) |=> (flags_q == $past(alu_flags))); // R8

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(commit_en && flag_upd) |=> $stable(flags_q)); // R9

endmodule

// File: tb/pred_commit_unit_bench.sv
module pred_commit_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEST_W = 5;
  localparam int DATA_W = 32;
  localparam int NVEC = 25;

  // {stored flags S C V Z, condition code, expected pass}
  localparam logic [8:0] VEC [NVEC] = '{
    {4'b0000, 4'b0000, 1'b1}, {4'b0001, 4'b0000, 1'b0}, {4'b0001, 4'b0001, 1'b1},
    {4'b0000, 4'b0010, 1'b1}, {4'b0010, 4'b0011, 1'b1}, {4'b0100, 4'b0100, 1'b0},
    {4'b0100, 4'b0101, 1'b1}, {4'b1000, 4'b0110, 1'b0}, {4'b1000, 4'b0111, 1'b1},
    {4'b0000, 4'b1000, 1'b1}, {4'b0001, 4'b1000, 1'b0}, {4'b0100, 4'b1001, 1'b1},
    {4'b0000, 4'b1001, 1'b0}, {4'b1010, 4'b1010, 1'b1}, {4'b1000, 4'b1010, 1'b0},
    {4'b1000, 4'b1011, 1'b1}, {4'b0010, 4'b1011, 1'b1}, {4'b0000, 4'b1100, 1'b1},
    {4'b0001, 4'b1100, 1'b0}, {4'b1000, 4'b1100, 1'b0}, {4'b0001, 4'b1101, 1'b1},
    {4'b0000, 4'b1101, 1'b0}, {4'b1111, 4'b1110, 1'b1}, {4'b0000, 4'b1111, 1'b0},
    {4'b0000, 4'b1110, 1'b1}
  };

  logic clk = 1'b0;
  logic rst;
  logic res_valid, wr_req, flag_upd;
  logic [3:0] cond_code, alu_flags;
  logic [DEST_W-1:0] wr_dest;
  logic [DATA_W-1:0] wr_data;
  logic commit_en, rf_we;
  logic [DEST_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic [3:0] flags_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pred_commit_unit #(.DEST_W(DEST_W), .DATA_W(DATA_W)) u_pred_commit_unit (
    .clk(clk), .rst(rst), .res_valid(res_valid), .cond_code(cond_code),
    .wr_req(wr_req), .wr_dest(wr_dest), .wr_data(wr_data), .flag_upd(flag_upd),
    .alu_flags(alu_flags), .commit_en(commit_en), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .flags_q(flags_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [3:0] c, logic we, logic fu, logic [3:0] af);
    res_valid = v; cond_code = c; wr_req = we; flag_upd = fu; alu_flags = af;
  endtask

  task automatic plant(logic [3:0] f);
    @(negedge clk);
    drive(1'b1, 4'b1110, 1'b0, 1'b1, f);
    @(negedge clk);
    drive(1'b0, 4'b1110, 1'b0, 1'b0, 4'b0000);
  endtask

  function automatic string req_of(logic [3:0] c);
    if (c[3] == 1'b0) return "R2";
    if (c[3:1] == 3'b100) return "R3";
    if (c[3:1] == 3'b111) return "R5";
    return "R4";
  endfunction

  initial begin
    rst = 1'b1;
    wr_dest = '0; wr_data = '0;
    drive(1'b0, 4'b0000, 1'b0, 1'b0, 4'b0000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset flags", flags_q, 4'b0000);
    rst = 1'b0;

    // R6: valid low blocks even an always-pass code
    drive(1'b0, 4'b1110, 1'b1, 1'b1, 4'b1111);
    #1 check("R6 idle commit", commit_en, 1'b0);
    check("R6 idle write", rf_we, 1'b0);
    @(negedge clk);
    check("R6 idle flags", flags_q, 4'b0000);

    // Table walk: R2..R5 and R1 layout/R8 load
    for (int i = 0; i < NVEC; i++) begin
      plant(VEC[i][8:5]);
      check("R8 flag load", flags_q, VEC[i][8:5]);
      drive(1'b1, VEC[i][4:1], 1'b0, 1'b0, 4'b0000);
      #1 check(req_of(VEC[i][4:1]), commit_en, VEC[i][0]);
      drive(1'b0, 4'b1110, 1'b0, 1'b0, 4'b0000);
    end

    // R7: passing write drives the port
    plant(4'b0000);
    @(negedge clk);
    wr_dest = 5'd19; wr_data = 32'hCAFE_0123;
    drive(1'b1, 4'b0000, 1'b1, 1'b0, 4'b0000);
    #1 check("R7 we", rf_we, 1'b1);
    check("R7 addr", rf_waddr, 5'd19);
    check("R7 data", rf_wdata, 32'hCAFE_0123);
    drive(1'b1, 4'b0000, 1'b0, 1'b0, 4'b0000);
    #1 check("R7 no request", rf_we, 1'b0);

    // R9: failing condition writes nothing and keeps flags
    plant(4'b0001);
    @(negedge clk);
    drive(1'b1, 4'b0000, 1'b1, 1'b1, 4'b1110);
    #1 check("R9 no write", rf_we, 1'b0);
    @(negedge clk);
    drive(1'b0, 4'b1110, 1'b0, 1'b0, 4'b0000);
    check("R9 flags kept", flags_q, 4'b0001);

    // R5: never code with update request leaves flags
    @(negedge clk);
    drive(1'b1, 4'b1111, 1'b1, 1'b1, 4'b0110);
    #1 check("R5 never write", rf_we, 1'b0);
    @(negedge clk);
    check("R5 never flags", flags_q, 4'b0001);

    // R10: own flags would pass, stored ones fail
    plant(4'b0000);
    @(negedge clk);
    drive(1'b1, 4'b0001, 1'b1, 1'b1, 4'b0001);
    #1 check("R10 judged on old", commit_en, 1'b0);
    @(negedge clk);
    check("R10 no self load", flags_q, 4'b0000);
    // R10: stored flags pass, own would fail; new flags land after edge
    plant(4'b0001);
    @(negedge clk);
    drive(1'b1, 4'b0001, 1'b0, 1'b1, 4'b0100);
    #1 check("R10 pass on old", commit_en, 1'b1);
    check("R10 flags before edge", flags_q, 4'b0001);
    @(negedge clk);
    drive(1'b0, 4'b1110, 1'b0, 1'b0, 4'b0000);
    check("R10 flags after edge", flags_q, 4'b0100);

    // R3: unsigned compare 3 - 9 borrows, so C=1 and "below" passes
    plant({1'b1, 1'b1, 1'b0, 1'b0});
    @(negedge clk);
    drive(1'b1, 4'b0101, 1'b0, 1'b0, 4'b0000);
    #1 check("R3 below after borrow", commit_en, 1'b1);
    drive(1'b1, 4'b1000, 1'b0, 1'b0, 4'b0000);
    #1 check("R3 above after borrow", commit_en, 1'b0);

    // R1: reset clears loaded flags
    @(negedge clk);
    rst = 1'b1;
    drive(1'b0, 4'b1110, 1'b0, 1'b0, 4'b0000);
    @(negedge clk);
    check("R1 reset clears", flags_q, 4'b0000);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule